// File: doc/BRIEF.md
# Cross-Domain Debug Command Mailbox

This block connects a debug access port running on the JTAG clock to a debug engine running on the CPU clock. It holds a small window of four 32-bit words: a command, an argument (address or register number), an operand, and a result. The JTAG side stages the argument and operand, then writes the command word. That write starts a four-phase request/complete handshake toward the CPU domain. The result word is filled only from the CPU domain.

Every JTAG read returns 33 bits. The low 32 bits hold the addressed word. The top bit tells the debugger whether the result belongs to a command that has finished and has not yet been replaced by a newer one.

Each control signal crosses into the other domain through a multi-flop synchronizer. The CPU side takes a private copy of the staged words at the moment it accepts a request. While a handshake is in flight, the JTAG side refuses any write to the staged words. It records each refused write in a sticky overrun flag.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset, `jtag_busy`, `jtag_overrun` and `cpu_req` are 0, and reading any word address returns 0 with bit 32 clear.
- R2: A JTAG write to word address 1 or 2 while not busy stores the data. A read strobe returns {valid, word} on `jtag_rdata` with `jtag_rd_valid` high on the clock edge after the strobe. Word addresses are 0 = command, 1 = argument, 2 = operand, 3 = result.
- R3: JTAG writes to word address 3 are discarded. Word 3 always reads the last value the CPU side wrote with `cpu_result_we`.
- R4: A write to word 0 while not busy stores the command and raises `jtag_busy` at the next edge. `cpu_req` then rises after synchronization. At that time `cpu_cmd`, `cpu_arg` and `cpu_opnd` equal the staged words 0, 1 and 2.
- R5: Once the synchronized `cpu_done` is seen high, the request is withdrawn and `cpu_req` falls. `jtag_busy` stays high until `cpu_done` has been seen low again.
- R6: Bit 32 of a read is 0 while a request is pending. It becomes 1 once completion is seen and stays 1 until the next accepted command write.
- R7: Writes to words 0, 1 or 2 while busy leave the stored words unchanged and set `jtag_overrun`. The flag stays set until the next accepted command write clears it.
- R8: While `cpu_req` stays high, `cpu_cmd`, `cpu_arg` and `cpu_opnd` do not change.
- R9: When a read and a write to the same word occur in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| jtag_clk | input | 1 | JTAG-side clock |
| jtag_rst_n | input | 1 | JTAG-side synchronous active-low reset |
| jtag_wr_en | input | 1 | Word write strobe |
| jtag_rd_en | input | 1 | Word read strobe |
| jtag_addr | input | 2 | Word address |
| jtag_wdata | input | 32 | Write data |
| jtag_rdata | output | 33 | {valid, word} read result |
| jtag_rd_valid | output | 1 | Read result present this cycle |
| jtag_busy | output | 1 | Handshake in progress |
| jtag_overrun | output | 1 | Sticky flag for writes refused while busy |
| cpu_clk | input | 1 | CPU-side clock |
| cpu_rst_n | input | 1 | CPU-side synchronous active-low reset |
| cpu_req | output | 1 | Command request to the debug engine |
| cpu_cmd | output | 32 | Captured command word |
| cpu_arg | output | 32 | Captured argument word |
| cpu_opnd | output | 32 | Captured operand word |
| cpu_done | input | 1 | Completion from the debug engine |
| cpu_result_we | input | 1 | Result word write strobe |
| cpu_result | input | 32 | Result word data |

## Verification
The assertions assume the debug engine obeys the four-phase protocol. It raises `cpu_done` only while `cpu_req` is high and lowers it only after `cpu_req` has fallen. They also assume read and write strobes are single JTAG-clock pulses. The bench's engine model waits on `cpu_req` before each edge of `cpu_done` and writes the result before raising completion. The bench drives every JTAG strobe for exactly one cycle from the falling edge.

// File: rtl/dbgmb_pkg.sv
// Package: shared word indices and handshake state encoding for the
// debug command mailbox. Assumes a fixed four-word window.
package dbgmb_pkg;
    localparam int NUM_WORDS = 4;
    localparam int ADDR_W    = $clog2(NUM_WORDS);

    typedef enum logic [ADDR_W-1:0] {
        WIDX_CMD  = 2'd0,
        WIDX_ARG  = 2'd1,
        WIDX_OPND = 2'd2,
        WIDX_RSLT = 2'd3
    } widx_e;

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_REQ   = 2'd1,
        HS_DRAIN = 2'd2
    } hs_state_e;
endpackage

// File: rtl/dbgmb_sync.sv
// Module: multi-flop level synchronizer into the destination clock.
// Assumes a level input that is held for several destination cycles.
module dbgmb_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift the level one flop further along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else begin
                    stage_q[s] <= (s == 0) ? d : stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dbgmb_hs_fsm.sv
// Module: JTAG-domain four-phase handshake controller and valid flag.
// Assumes done_sync is already synchronized into the JTAG clock.
module dbgmb_hs_fsm
    import dbgmb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic done_sync,
    output logic busy,
    output logic req,
    output logic valid
);
    hs_state_e state_q;
    logic      req_q;
    logic      valid_q;

    // Step the handshake: launch, wait for done high, then for done low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
            req_q   <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            unique case (state_q)
                HS_IDLE: begin
                    if (launch) begin
                        state_q <= HS_REQ;
                        req_q   <= 1'b1;
                        valid_q <= 1'b0;
                    end
                end
                HS_REQ: begin
                    if (done_sync) begin
                        state_q <= HS_DRAIN;
                        req_q   <= 1'b0;
                        valid_q <= 1'b1;
                    end
                end
                HS_DRAIN: begin
                    if (!done_sync) begin
                        state_q <= HS_IDLE;
                    end
                end
                default: begin
                    state_q <= HS_IDLE;
                    req_q   <= 1'b0;
                end
            endcase
        end
    end

    assign busy  = (state_q != HS_IDLE);
    assign req   = req_q;
    assign valid = valid_q;
endmodule

// File: rtl/dbgmb_jtag_regs.sv
// Module: JTAG-domain staged words, overrun flag and registered read port.
// Assumes result_word comes from the CPU domain and is qualified by valid.
module dbgmb_jtag_regs
    import dbgmb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    input  logic              valid,
    input  logic [DATA_W-1:0] result_word,
    output logic              launch,
    output logic              overrun,
    output logic [DATA_W:0]   rdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] word_cmd,
    output logic [DATA_W-1:0] word_arg,
    output logic [DATA_W-1:0] word_opnd
);
    localparam int STAGED = NUM_WORDS - 1;

    logic [DATA_W-1:0] word_q [STAGED];
    logic              staged_hit;
    logic [DATA_W-1:0] rd_mux;
    logic              overrun_q;
    logic [DATA_W:0]   rdata_q;
    logic              rd_valid_q;

    assign staged_hit = wr_en && (addr != WIDX_RSLT);
    assign launch     = wr_en && (addr == WIDX_CMD) && !busy;

    genvar w;
    generate
        for (w = 0; w < STAGED; w++) begin : g_word
            // Store one staged word when addressed and no handshake runs.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word_q[w] <= '0;
                end else if (wr_en && !busy && (addr == ADDR_W'(w))) begin
                    word_q[w] <= wdata;
                end
            end
        end
    endgenerate

    // Record refused writes; a new accepted command clears the record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun_q <= 1'b0;
        end else if (launch) begin
            overrun_q <= 1'b0;
        end else if (staged_hit && busy) begin
            overrun_q <= 1'b1;
        end
    end

    // Select the addressed word for the read port.
    always_comb begin
        unique case (addr)
            WIDX_CMD:  rd_mux = word_q[0];
            WIDX_ARG:  rd_mux = word_q[1];
            WIDX_OPND: rd_mux = word_q[2];
            default:   rd_mux = result_word;
        endcase
    end

    // Register the read result with the completion flag on top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q    <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= rd_en;
            if (rd_en) begin
                rdata_q <= {valid, rd_mux};
            end
        end
    end

    assign overrun   = overrun_q;
    assign rdata     = rdata_q;
    assign rd_valid  = rd_valid_q;
    assign word_cmd  = word_q[0];
    assign word_arg  = word_q[1];
    assign word_opnd = word_q[2];
endmodule

// File: rtl/dbgmb_cpu_side.sv
// Module: CPU-domain request capture, completion register and result word.
// Assumes staged words are frozen while the request is raised.
module dbgmb_cpu_side #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_sync,
    input  logic [DATA_W-1:0] src_cmd,
    input  logic [DATA_W-1:0] src_arg,
    input  logic [DATA_W-1:0] src_opnd,
    input  logic              done_in,
    input  logic              result_we,
    input  logic [DATA_W-1:0] result_in,
    output logic              req_out,
    output logic [DATA_W-1:0] cmd_out,
    output logic [DATA_W-1:0] arg_out,
    output logic [DATA_W-1:0] opnd_out,
    output logic              done_reg,
    output logic [DATA_W-1:0] result_reg
);
    logic              req_q;
    logic [DATA_W-1:0] cmd_q, arg_q, opnd_q;
    logic              done_q;
    logic [DATA_W-1:0] result_q;

    // Follow the synchronized request, snapshotting words as it rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            cmd_q  <= '0;
            arg_q  <= '0;
            opnd_q <= '0;
        end else begin
            req_q <= req_sync;
            if (req_sync && !req_q) begin
                cmd_q  <= src_cmd;
                arg_q  <= src_arg;
                opnd_q <= src_opnd;
            end
        end
    end

    // Launch completion from a flop so the crossing sees a clean level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= done_in;
        end
    end

    // Hold the result word written by the debug engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (result_we) begin
            result_q <= result_in;
        end
    end

    assign req_out    = req_q;
    assign cmd_out    = cmd_q;
    assign arg_out    = arg_q;
    assign opnd_out   = opnd_q;
    assign done_reg   = done_q;
    assign result_reg = result_q;
endmodule

// File: rtl/dbg_mailbox.sv
// Module: top of the cross-domain debug command mailbox. Joins the JTAG
// word store, the handshake controller, the CPU-side capture and the two
// synchronizers. Assumes independent clocks with their own resets.
module dbg_mailbox
    import dbgmb_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              jtag_clk,
    input  logic              jtag_rst_n,
    input  logic              jtag_wr_en,
    input  logic              jtag_rd_en,
    input  logic [1:0]        jtag_addr,
    input  logic [DATA_W-1:0] jtag_wdata,
    output logic [DATA_W:0]   jtag_rdata,
    output logic              jtag_rd_valid,
    output logic              jtag_busy,
    output logic              jtag_overrun,
    input  logic              cpu_clk,
    input  logic              cpu_rst_n,
    output logic              cpu_req,
    output logic [DATA_W-1:0] cpu_cmd,
    output logic [DATA_W-1:0] cpu_arg,
    output logic [DATA_W-1:0] cpu_opnd,
    input  logic              cpu_done,
    input  logic              cpu_result_we,
    input  logic [DATA_W-1:0] cpu_result
);
    logic              hs_launch;
    logic              hs_req;
    logic              hs_valid;
    logic              done_sync_j;
    logic              req_sync_c;
    logic              done_reg_c;
    logic [DATA_W-1:0] result_c;
    logic [DATA_W-1:0] staged_cmd, staged_arg, staged_opnd;

    dbgmb_jtag_regs #(.DATA_W(DATA_W)) u_regs (
        .clk         (jtag_clk),
        .rst_n       (jtag_rst_n),
        .wr_en       (jtag_wr_en),
        .rd_en       (jtag_rd_en),
        .addr        (jtag_addr),
        .wdata       (jtag_wdata),
        .busy        (jtag_busy),
        .valid       (hs_valid),
        .result_word (result_c),
        .launch      (hs_launch),
        .overrun     (jtag_overrun),
        .rdata       (jtag_rdata),
        .rd_valid    (jtag_rd_valid),
        .word_cmd    (staged_cmd),
        .word_arg    (staged_arg),
        .word_opnd   (staged_opnd)
    );

    dbgmb_hs_fsm u_fsm (
        .clk       (jtag_clk),
        .rst_n     (jtag_rst_n),
        .launch    (hs_launch),
        .done_sync (done_sync_j),
        .busy      (jtag_busy),
        .req       (hs_req),
        .valid     (hs_valid)
    );

    dbgmb_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (cpu_clk),
        .rst_n (cpu_rst_n),
        .d     (hs_req),
        .q     (req_sync_c)
    );

    dbgmb_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_done_sync (
        .clk   (jtag_clk),
        .rst_n (jtag_rst_n),
        .d     (done_reg_c),
        .q     (done_sync_j)
    );

    dbgmb_cpu_side #(.DATA_W(DATA_W)) u_cpu (
        .clk        (cpu_clk),
        .rst_n      (cpu_rst_n),
        .req_sync   (req_sync_c),
        .src_cmd    (staged_cmd),
        .src_arg    (staged_arg),
        .src_opnd   (staged_opnd),
        .done_in    (cpu_done),
        .result_we  (cpu_result_we),
        .result_in  (cpu_result),
        .req_out    (cpu_req),
        .cmd_out    (cpu_cmd),
        .arg_out    (cpu_arg),
        .opnd_out   (cpu_opnd),
        .done_reg   (done_reg_c),
        .result_reg (result_c)
    );
endmodule

// File: rtl/dbgmb_checker.sv
// Module: protocol checker for the mailbox, bound to the top. Assumes
// single-cycle JTAG strobes and a four-phase compliant debug engine.
module dbgmb_checker #(
    parameter int DATA_W = 32
) (
    input logic              jtag_clk,
    input logic              jtag_rst_n,
    input logic              cpu_clk,
    input logic              cpu_rst_n,
    input logic              jtag_wr_en,
    input logic              jtag_rd_en,
    input logic [1:0]        jtag_addr,
    input logic              jtag_rd_valid,
    input logic              jtag_busy,
    input logic              jtag_overrun,
    input logic              hs_req,
    input logic              hs_valid,
    input logic              cpu_req,
    input logic [DATA_W-1:0] cpu_cmd,
    input logic [DATA_W-1:0] cpu_arg,
    input logic [DATA_W-1:0] cpu_opnd
);
    AST_READ_STROBE: assert property (@(posedge jtag_clk) disable iff (!jtag_rst_n)
        jtag_rd_en |=> jtag_rd_valid); // R2

    AST_LAUNCH_BUSY: assert property (@(posedge jtag_clk) disable iff (!jtag_rst_n)
        (jtag_wr_en && jtag_addr == 2'd0 && !jtag_busy) |=> jtag_busy); // R4

    AST_REQ_NO_VALID: assert property (@(posedge jtag_clk) disable iff (!jtag_rst_n)
        hs_req |-> !hs_valid); // R6

    AST_REQ_WITHIN_BUSY: assert property (@(posedge jtag_clk) disable iff (!jtag_rst_n)
        hs_req |-> jtag_busy); // R5

    AST_BUSY_WRITE_FLAGGED: assert property (@(posedge jtag_clk) disable iff (!jtag_rst_n)
        (jtag_busy && jtag_wr_en && jtag_addr != 2'd3) |=> jtag_overrun); // R7

    AST_OVERRUN_STICKY: assert property (@(posedge jtag_clk) disable iff (!jtag_rst_n)
        (jtag_overrun && !(jtag_wr_en && jtag_addr == 2'd0 && !jtag_busy)) |=> jtag_overrun); // R7

    AST_OPERANDS_HELD: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        (cpu_req && $past(cpu_req)) |-> ($stable(cpu_cmd) && $stable(cpu_arg) && $stable(cpu_opnd))); // R8
endmodule

bind dbg_mailbox dbgmb_checker #(.DATA_W(DATA_W)) u_chk (
    .jtag_clk      (jtag_clk),
    .jtag_rst_n    (jtag_rst_n),
    .cpu_clk       (cpu_clk),
    .cpu_rst_n     (cpu_rst_n),
    .jtag_wr_en    (jtag_wr_en),
    .jtag_rd_en    (jtag_rd_en),
    .jtag_addr     (jtag_addr),
    .jtag_rd_valid (jtag_rd_valid),
    .jtag_busy     (jtag_busy),
    .jtag_overrun  (jtag_overrun),
    .hs_req        (hs_req),
    .hs_valid      (hs_valid),
    .cpu_req       (cpu_req),
    .cpu_cmd       (cpu_cmd),
    .cpu_arg       (cpu_arg),
    .cpu_opnd      (cpu_opnd)
);

// File: tb/dbg_mailbox_bench.sv
module dbg_mailbox_bench;
    localparam int DW = 32;

    logic          jtag_clk = 1'b0;
    logic          cpu_clk  = 1'b0;
    logic          jtag_rst_n = 1'b0;
    logic          cpu_rst_n  = 1'b0;
    logic          jtag_wr_en = 1'b0;
    logic          jtag_rd_en = 1'b0;
    logic [1:0]    jtag_addr  = '0;
    logic [DW-1:0] jtag_wdata = '0;
    logic [DW:0]   jtag_rdata;
    logic          jtag_rd_valid;
    logic          jtag_busy;
    logic          jtag_overrun;
    logic          cpu_req;
    logic [DW-1:0] cpu_cmd, cpu_arg, cpu_opnd;
    logic          cpu_done = 1'b0;
    logic          cpu_result_we = 1'b0;
    logic [DW-1:0] cpu_result = '0;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [DW:0] value;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #10 jtag_clk = ~jtag_clk;
    always #7  cpu_clk  = ~cpu_clk;

    dbg_mailbox u_dbg_mailbox (
        .jtag_clk      (jtag_clk),
        .jtag_rst_n    (jtag_rst_n),
        .jtag_wr_en    (jtag_wr_en),
        .jtag_rd_en    (jtag_rd_en),
        .jtag_addr     (jtag_addr),
        .jtag_wdata    (jtag_wdata),
        .jtag_rdata    (jtag_rdata),
        .jtag_rd_valid (jtag_rd_valid),
        .jtag_busy     (jtag_busy),
        .jtag_overrun  (jtag_overrun),
        .cpu_clk       (cpu_clk),
        .cpu_rst_n     (cpu_rst_n),
        .cpu_req       (cpu_req),
        .cpu_cmd       (cpu_cmd),
        .cpu_arg       (cpu_arg),
        .cpu_opnd      (cpu_opnd),
        .cpu_done      (cpu_done),
        .cpu_result_we (cpu_result_we),
        .cpu_result    (cpu_result)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: single-cycle write.
    task automatic jwrite(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge jtag_clk);
        jtag_wr_en = 1'b1; jtag_addr = a; jtag_wdata = d;
        @(negedge jtag_clk);
        jtag_wr_en = 1'b0;
    endtask

    // Driver: single-cycle read; expected item goes to the scoreboard.
    task automatic jread(input logic [1:0] a, input logic [DW:0] exp, input string tag);
        @(negedge jtag_clk);
        jtag_rd_en = 1'b1; jtag_addr = a;
        sb_q.push_back('{value: exp, tag: tag});
        @(negedge jtag_clk);
        jtag_rd_en = 1'b0;
    endtask

    // Driver: read and write the same word in one cycle.
    task automatic jrw(input logic [1:0] a, input logic [DW-1:0] d, input logic [DW:0] exp, input string tag);
        @(negedge jtag_clk);
        jtag_rd_en = 1'b1; jtag_wr_en = 1'b1; jtag_addr = a; jtag_wdata = d;
        sb_q.push_back('{value: exp, tag: tag});
        @(negedge jtag_clk);
        jtag_rd_en = 1'b0; jtag_wr_en = 1'b0;
    endtask

    // Monitor: compare each returned read with the queued expectation.
    always @(negedge jtag_clk) begin
        if (jtag_rd_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R2 unexpected read", 64'(jtag_rdata), 64'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(jtag_rdata === e.value, e.tag, 64'(jtag_rdata), 64'(e.value));
            end
        end
    end

    // Debug engine model: serve one command following the four-phase rule.
    task automatic cpu_serve(input logic [DW-1:0] ecmd, input logic [DW-1:0] earg,
                             input logic [DW-1:0] eopnd, input logic [DW-1:0] res);
        wait (cpu_req === 1'b1);
        @(negedge cpu_clk);
        check(cpu_cmd === ecmd,   "R4 cpu_cmd",  64'(cpu_cmd),  64'(ecmd));
        check(cpu_arg === earg,   "R4 cpu_arg",  64'(cpu_arg),  64'(earg));
        check(cpu_opnd === eopnd, "R8 cpu_opnd", 64'(cpu_opnd), 64'(eopnd));
        cpu_result_we = 1'b1; cpu_result = res;
        @(negedge cpu_clk);
        cpu_result_we = 1'b0;
        cpu_done = 1'b1;
        wait (cpu_req === 1'b0);
        repeat (6) @(negedge cpu_clk);
        check(jtag_busy === 1'b1, "R5 busy held while done high", 64'(jtag_busy), 64'd1);
        cpu_done = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge jtag_clk);
        if (!finished) begin
            check(1'b0, "watchdog expired", 64'd0, 64'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        repeat (4) @(negedge jtag_clk);
        jtag_rst_n = 1'b1; cpu_rst_n = 1'b1;
        @(negedge jtag_clk);
        // R1: reset state
        check(jtag_busy === 1'b0,    "R1 busy",    64'(jtag_busy), 64'd0);
        check(jtag_overrun === 1'b0, "R1 overrun", 64'(jtag_overrun), 64'd0);
        check(cpu_req === 1'b0,      "R1 cpu_req", 64'(cpu_req), 64'd0);
        for (int i = 0; i < 4; i++) jread(2'(i), '0, "R1 reset word");

        // R2: staging words
        jwrite(2'd1, 32'h1000_0040);
        jwrite(2'd2, 32'hCAFE_F00D);
        jread(2'd1, {1'b0, 32'h1000_0040}, "R2 arg word");
        jread(2'd2, {1'b0, 32'hCAFE_F00D}, "R2 opnd word");

        // R9: same-cycle read and write returns the previous value
        jrw(2'd1, 32'h2000_0080, {1'b0, 32'h1000_0040}, "R9 read-before-write");
        jread(2'd1, {1'b0, 32'h2000_0080}, "R9 new value");

        // R3: JTAG writes to the result word are discarded
        jwrite(2'd3, 32'hDEAD_BEEF);
        jread(2'd3, {1'b0, 32'h0}, "R3 result write discarded");

        // R4..R7: first command
        fork
            cpu_serve(32'h5, 32'h2000_0080, 32'hCAFE_F00D, 32'h1234_5678);
            begin
                jwrite(2'd0, 32'h5);
                check(jtag_busy === 1'b1, "R4 busy after launch", 64'(jtag_busy), 64'd1);
                jread(2'd0, {1'b0, 32'h5}, "R6 valid clear while pending");
                jwrite(2'd1, 32'h0BAD_0BAD);
                check(jtag_overrun === 1'b1, "R7 overrun set", 64'(jtag_overrun), 64'd1);
                jread(2'd1, {1'b0, 32'h2000_0080}, "R7 arg unchanged while busy");
            end
        join
        wait (jtag_busy === 1'b0);
        jread(2'd3, {1'b1, 32'h1234_5678}, "R6 valid with result");
        jread(2'd1, {1'b1, 32'h2000_0080}, "R7 refused write not stored");
        check(jtag_overrun === 1'b1, "R7 overrun sticky", 64'(jtag_overrun), 64'd1);
        check(cpu_req === 1'b0, "R5 request withdrawn", 64'(cpu_req), 64'd0);

        // Second command clears overrun and valid
        fork
            cpu_serve(32'hE, 32'h2000_0080, 32'hCAFE_F00D, 32'h0000_0001);
            begin
                jwrite(2'd0, 32'hE);
                check(jtag_overrun === 1'b0, "R7 overrun cleared by launch", 64'(jtag_overrun), 64'd0);
                jread(2'd2, {1'b0, 32'hCAFE_F00D}, "R6 valid cleared by new command");
                jwrite(2'd0, 32'h3);
                check(jtag_overrun === 1'b1, "R7 command write refused", 64'(jtag_overrun), 64'd1);
            end
        join
        wait (jtag_busy === 1'b0);
        jread(2'd3, {1'b1, 32'h0000_0001}, "R3 result from cpu side");
        jread(2'd0, {1'b1, 32'hE}, "R7 refused command not stored");
        repeat (3) @(negedge jtag_clk);
        check(sb_q.size() == 0, "R2 all reads returned", 64'(sb_q.size()), 64'd0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule